// File: doc/BRIEF.md
# Multidrop Receiver Wakeup Controller

This block decides, on a serial line shared by many receivers, when a receiver that has been put to sleep should start delivering characters again. Software raises a sleep request. From then on, completed frames are withheld: no data-ready pulse, and so no receive interrupt. The hardware clears the sleep state on its own when the selected wakeup event occurs.

Two wakeup events are available:
- **Idle-line wakeup:** the line stays at one for a full idle character.
- **Address-mark wakeup:** a frame arrives whose last data bit is one.

The same logic drives an idle-line flag. Idle-bit counting can begin either right after a start bit or only after the stop bit of a frame. The receiver datapath sits next to this block and supplies three things: a strobe once per bit time with the sampled bit, a pulse when a start bit is detected, and a pulse when a frame completes together with that frame's last data bit.

Top module: `rx_wakeup_ctrl`

## Requirements
- R1: After reset, `sleep`, `frame_pass` and `idle_flag` are all 0, and idle counting is armed.
- R2: A `sleep_req` pulse sets `sleep` at the next clock edge. `sleep` then holds until a wakeup event clears it.
- R3: While `sleep` is 1, a `frame_done` pulse gives no `frame_pass` unless it is an address-mark wakeup frame (R4).
- R4: Address-mark wakeup applies when `wake_sel`=1. A frame completing while asleep with `frame_msb`=1 clears `sleep` and is itself passed: `frame_pass` is 1 for one cycle, one cycle after `frame_done`.
- R5: With `wake_sel`=1, a frame completing while asleep with `frame_msb`=0 is withheld, and `sleep` stays 1.
- R6: Idle-line wakeup applies when `wake_sel`=0. Detection of an idle character clears `sleep` in the same cycle that `idle_flag` rises, and the next frame is passed. While asleep in this mode, frames are withheld whatever their last bit.
- R7: An idle character is 8 consecutive armed bit strobes with `rx_bit`=1 when `wide_char`=0, or 9 when `wide_char`=1. A strobe with `rx_bit`=0 restarts the count.
- R8: With `count_mode`=0, a `start_det` pulse arms counting. With `count_mode`=1, `start_det` disarms counting and only `frame_done` arms it, so bits inside a frame are not counted.
- R9: `idle_flag` is raised once per idle period and stays 1 through further ones. Only `start_det` clears it, and that also allows a new detection.
- R10: While awake, every `frame_done` pulse produces exactly one `frame_pass` pulse one cycle later. `frame_pass` never occurs without a preceding `frame_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wake_sel | input | 1 | 0 = idle-line wakeup, 1 = address-mark wakeup |
| count_mode | input | 1 | 0 = count idle bits from start bit, 1 = from stop bit |
| wide_char | input | 1 | 0 = 8-bit idle character, 1 = 9-bit |
| sleep_req | input | 1 | Pulse: enter sleep |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| rx_bit | input | 1 | Sampled line value, valid with `bit_tick` |
| start_det | input | 1 | Pulse: start bit detected |
| frame_done | input | 1 | Pulse: frame complete |
| frame_msb | input | 1 | Last data bit of the completed frame |
| sleep | output | 1 | Receiver sleep state |
| frame_pass | output | 1 | Pulse: completed frame delivered as valid data |
| idle_flag | output | 1 | Idle line detected |

## Verification
The properties assume the following about the receiver's pulses:
- `start_det`, `frame_done` and `bit_tick` never coincide.
- `sleep_req` is not issued in the same cycle as a wakeup frame.

The stimulus drives each event as a separate one-cycle pulse at the falling clock edge, so these conditions always hold. Checks on the flag and the sleep state are taken after the complete pulse has been clocked.

// File: rtl/wake_pkg.sv
package wake_pkg;

    typedef enum logic {
        WAKE_IDLE = 1'b0,
        WAKE_ADDR = 1'b1
    } wake_mode_e;

    typedef enum logic {
        CNT_AFTER_START = 1'b0,
        CNT_AFTER_STOP  = 1'b1
    } count_mode_e;

    typedef struct packed {
        logic armed;   // ones are being counted
        logic locked;  // detection done, waiting for a start bit
        logic flag;    // idle line reported
    } idle_state_t;

    // Number of consecutive ones forming an idle character.
    function automatic int unsigned idle_len(input int unsigned base, input logic wide);
        return base + (wide ? 1 : 0);
    endfunction

endpackage

// File: rtl/idle_detector.sv
module idle_detector
    import wake_pkg::*;
#(
    parameter int unsigned BASE_BITS = 8,
    parameter int unsigned CNT_W     = $clog2(BASE_BITS + 2)
) (
    input  logic clk,
    input  logic rst,
    input  logic count_mode,
    input  logic wide_char,
    input  logic bit_tick,
    input  logic rx_bit,
    input  logic start_det,
    input  logic frame_done,
    output logic idle_hit,
    output logic idle_flag
);

    idle_state_t st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] last_idx;
    count_mode_e mode;

    assign mode     = count_mode_e'(count_mode);
    assign last_idx = CNT_W'(idle_len(BASE_BITS, wide_char) - 1);

    assign idle_hit = bit_tick && rx_bit && st_q.armed && !st_q.locked
                      && !start_det && (cnt_q == last_idx);

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (start_det) begin
            st_d.flag   = 1'b0;
            st_d.locked = 1'b0;
            st_d.armed  = (mode == CNT_AFTER_START);
            cnt_d       = '0;
        end else if (frame_done) begin
            if (mode == CNT_AFTER_STOP) begin
                st_d.armed = 1'b1;
                cnt_d      = '0;
            end
        end else if (idle_hit) begin
            st_d.flag   = 1'b1;
            st_d.locked = 1'b1;
            cnt_d       = '0;
        end else if (bit_tick && st_q.armed && !st_q.locked) begin
            cnt_d = rx_bit ? cnt_q + 1'b1 : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= '{armed: 1'b1, locked: 1'b0, flag: 1'b0};
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign idle_flag = st_q.flag;

endmodule

// File: rtl/sleep_ctrl.sv
module sleep_ctrl
    import wake_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wake_sel,
    input  logic sleep_req,
    input  logic frame_done,
    input  logic frame_msb,
    input  logic idle_hit,
    output logic sleep,
    output logic frame_pass
);

    wake_mode_e mode;
    logic sleep_q, pass_q;
    logic addr_wake, idle_wake, pass_d;

    assign mode      = wake_mode_e'(wake_sel);
    assign addr_wake = sleep_q && frame_done && frame_msb && (mode == WAKE_ADDR);
    assign idle_wake = sleep_q && idle_hit && (mode == WAKE_IDLE);
    assign pass_d    = frame_done && (!sleep_q || addr_wake);

    always_ff @(posedge clk) begin
        if (rst) begin
            sleep_q <= 1'b0;
            pass_q  <= 1'b0;
        end else begin
            pass_q <= pass_d;
            if (sleep_req)
                sleep_q <= 1'b1;
            else if (addr_wake || idle_wake)
                sleep_q <= 1'b0;
        end
    end

    assign sleep      = sleep_q;
    assign frame_pass = pass_q;

endmodule

// File: rtl/rx_wakeup_ctrl.sv
module rx_wakeup_ctrl
    import wake_pkg::*;
#(
    parameter int unsigned BASE_BITS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic wake_sel,
    input  logic count_mode,
    input  logic wide_char,
    input  logic sleep_req,
    input  logic bit_tick,
    input  logic rx_bit,
    input  logic start_det,
    input  logic frame_done,
    input  logic frame_msb,
    output logic sleep,
    output logic frame_pass,
    output logic idle_flag
);

    localparam int unsigned CNT_W = $clog2(BASE_BITS + 2);

    logic idle_hit;

    idle_detector #(.BASE_BITS(BASE_BITS), .CNT_W(CNT_W)) u_idle (
        .clk        (clk),
        .rst        (rst),
        .count_mode (count_mode),
        .wide_char  (wide_char),
        .bit_tick   (bit_tick),
        .rx_bit     (rx_bit),
        .start_det  (start_det),
        .frame_done (frame_done),
        .idle_hit   (idle_hit),
        .idle_flag  (idle_flag)
    );

    sleep_ctrl u_sleep (
        .clk        (clk),
        .rst        (rst),
        .wake_sel   (wake_sel),
        .sleep_req  (sleep_req),
        .frame_done (frame_done),
        .frame_msb  (frame_msb),
        .idle_hit   (idle_hit),
        .sleep      (sleep),
        .frame_pass (frame_pass)
    );

endmodule

// File: rtl/rx_wakeup_ctrl_chk.sv
module rx_wakeup_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic wake_sel,
    input logic sleep_req,
    input logic start_det,
    input logic frame_done,
    input logic frame_msb,
    input logic sleep,
    input logic frame_pass,
    input logic idle_flag
);

    p_sleep_set_r2: assert property (@(posedge clk) disable iff (rst)
        sleep_req |=> sleep);

    p_sleep_fall_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(sleep) |-> (($past(!wake_sel) && $rose(idle_flag))
                          || $past(wake_sel && frame_done && frame_msb)));

    p_blocked_r3: assert property (@(posedge clk) disable iff (rst)
        (frame_done && sleep && !(wake_sel && frame_msb)) |=> !frame_pass);

    p_addr_wake_r4: assert property (@(posedge clk) disable iff (rst)
        (frame_done && sleep && wake_sel && frame_msb && !sleep_req)
        |=> (!sleep && frame_pass));

    p_awake_pass_r10: assert property (@(posedge clk) disable iff (rst)
        (frame_done && !sleep) |=> frame_pass);

    p_pass_cause_r10: assert property (@(posedge clk) disable iff (rst)
        frame_pass |-> $past(frame_done));

    p_flag_clear_r9: assert property (@(posedge clk) disable iff (rst)
        start_det |=> !idle_flag);

    p_flag_hold_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(idle_flag) |-> $past(start_det));

endmodule

bind rx_wakeup_ctrl rx_wakeup_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .wake_sel   (wake_sel),
    .sleep_req  (sleep_req),
    .start_det  (start_det),
    .frame_done (frame_done),
    .frame_msb  (frame_msb),
    .sleep      (sleep),
    .frame_pass (frame_pass),
    .idle_flag  (idle_flag)
);

// File: tb/test_rx_wakeup_ctrl.sv
module test_rx_wakeup_ctrl;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wake_sel = 1'b1, count_mode = 1'b0, wide_char = 1'b0;
    logic sleep_req = 1'b0, bit_tick = 1'b0, rx_bit = 1'b1;
    logic start_det = 1'b0, frame_done = 1'b0, frame_msb = 1'b0;
    logic sleep, frame_pass, idle_flag;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        logic  exp;
        string tag;
    } exp_item_t;

    exp_item_t exp_q[$];
    logic fd_q = 1'b0;

    rx_wakeup_ctrl i_rx_wakeup_ctrl (
        .clk(clk), .rst(rst), .wake_sel(wake_sel), .count_mode(count_mode),
        .wide_char(wide_char), .sleep_req(sleep_req), .bit_tick(bit_tick),
        .rx_bit(rx_bit), .start_det(start_det), .frame_done(frame_done),
        .frame_msb(frame_msb), .sleep(sleep), .frame_pass(frame_pass),
        .idle_flag(idle_flag)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // Monitor: compares frame_pass against the scoreboard.
    always @(posedge clk) fd_q <= frame_done;

    always @(negedge clk) begin
        if (!rst) begin
            if (fd_q) begin
                if (exp_q.size() == 0) begin
                    chk("R10 unexpected frame", 1'b1, 1'b0);
                end else begin
                    exp_item_t it;
                    it = exp_q.pop_front();
                    chk(it.tag, frame_pass, it.exp);
                end
            end else if (frame_pass) begin
                chk("R10 pass without frame", frame_pass, 1'b0);
            end
        end
    end

    task automatic tick(input logic b);
        bit_tick = 1'b1;
        rx_bit   = b;
        @(negedge clk);
        bit_tick = 1'b0;
        rx_bit   = 1'b1;
    endtask

    task automatic ones(input int n);
        for (int i = 0; i < n; i++) tick(1'b1);
    endtask

    task automatic frame(input logic msb, input logic exp, input string tag);
        exp_item_t it;
        it.exp = exp;
        it.tag = tag;
        exp_q.push_back(it);
        frame_done = 1'b1;
        frame_msb  = msb;
        @(negedge clk);
        frame_done = 1'b0;
        frame_msb  = 1'b0;
    endtask

    task automatic start_bit();
        start_det = 1'b1;
        @(negedge clk);
        start_det = 1'b0;
    endtask

    task automatic go_sleep();
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 sleep", sleep, 1'b0);
        chk("R1 pass", frame_pass, 1'b0);
        chk("R1 flag", idle_flag, 1'b0);

        // R1/R7: counting armed from reset, 8 ones form idle.
        ones(7);
        chk("R7 seven ones", idle_flag, 1'b0);
        ones(1);
        chk("R7 eighth one", idle_flag, 1'b1);
        ones(10);
        chk("R9 flag holds", idle_flag, 1'b1);
        start_bit();
        chk("R9 start clears", idle_flag, 1'b0);

        // R7: a zero restarts the count.
        ones(7);
        tick(1'b0);
        ones(7);
        chk("R7 restart", idle_flag, 1'b0);
        ones(1);
        chk("R7 after restart", idle_flag, 1'b1);

        // R10: awake frames pass.
        frame(1'b0, 1'b1, "R10 awake msb0");
        frame(1'b1, 1'b1, "R10 awake msb1");

        // Address-mark wakeup.
        wake_sel = 1'b1;
        go_sleep();
        chk("R2 sleep set", sleep, 1'b1);
        frame(1'b0, 1'b0, "R5 msb0 withheld");
        chk("R5 still asleep", sleep, 1'b1);
        start_bit();
        ones(12);
        chk("R2 idle ignored in addr mode", sleep, 1'b1);
        frame(1'b1, 1'b1, "R4 wake frame passed");
        chk("R4 awake", sleep, 1'b0);

        // Idle-line wakeup.
        wake_sel = 1'b0;
        go_sleep();
        start_bit();
        frame(1'b1, 1'b0, "R6 addr frame withheld");
        chk("R3 asleep", sleep, 1'b1);
        ones(7);
        chk("R6 not yet", sleep, 1'b1);
        ones(1);
        chk("R6 idle wakes", sleep, 1'b0);
        chk("R6 flag up", idle_flag, 1'b1);
        frame(1'b0, 1'b1, "R6 next frame passed");

        // Count after stop bit.
        count_mode = 1'b1;
        start_bit();
        ones(10);
        chk("R8 in-frame ones ignored", idle_flag, 1'b0);
        frame(1'b0, 1'b1, "R10 frame in stop mode");
        ones(7);
        chk("R8 seven after stop", idle_flag, 1'b0);
        ones(1);
        chk("R8 eight after stop", idle_flag, 1'b1);

        // Nine-bit idle character.
        wide_char = 1'b1;
        start_bit();
        frame(1'b0, 1'b1, "R10 frame wide");
        ones(8);
        chk("R7 wide eight", idle_flag, 1'b0);
        ones(1);
        chk("R7 wide nine", idle_flag, 1'b1);

        // Count after start bit again.
        count_mode = 1'b0;
        wide_char  = 1'b0;
        start_bit();
        ones(8);
        chk("R8 armed by start", idle_flag, 1'b1);

        repeat (3) @(negedge clk);
        chk("R10 queue drained", exp_q.size() == 0, 1'b1);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule